// File: doc/BRIEF.md
# Handset Power Mode Sequencer

This block is the supply-mode state machine of a battery-powered handset. It watches two comparator flags, one for the main battery and one for the back-up cell, each measured against the master-reset threshold. It also takes a flag for the running real-time-clock oscillator and four power-up events: key, charger, alarm and serial-bus wake. From these it decides which supply mode the system is in. Software can request sleep, flashing, a return to full operation and power-off.

On a power-up event the sequencer enters its start-up mode. The sleep clock supply is switched on at once. The analog, DRAM, IO and oscillator supplies then follow, one per slow-clock tick. The active-low system reset is held for `DELAY_TICKS` ticks of the 32.768 kHz tick input, which is 524 by default and so about 16 ms. After that the reset is released and the sequencer enters full operation. All outputs are registered, so the mode code and the enables change only at a clock edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is deasserted, and before any input changes, the outputs are as follows: `mode` is 0, `reg_en` is 0, `sys_rst_n` is 0, `lowq` is 0 and `pd_req` is 0.
- R2: While `main_ok` is 0, the next clock edge puts the block in mode 1 if both `backup_ok` and `rtc_run` are 1, and in mode 0 otherwise. This holds from every mode. In both cases `reg_en` is 0 and `sys_rst_n` is 0.
- R3: With `main_ok` at 1, modes 0 and 1 move to mode 2 on the next edge.
- R4: In mode 2, any one of `wake_key`, `wake_chg`, `wake_rtc` or `wake_bus` moves the block to mode 3 on the next edge. The tick count is reloaded and only `reg_en[0]` is set.
- R5: In mode 3, after k counted ticks, bits 0 through min(k,4) of `reg_en` are set. The bits stand for sleep clock (0), analog (1), DRAM (2), IO (3) and oscillator supply (4).
- R6: A clock edge without `tick32` does not advance mode 3. On the `DELAY_TICKS`-th tick the block enters mode 4, releases `sys_rst_n` and sets all five enables.
- R7: `sw_sleep` is acted on only in mode 4. In mode 5, `reg_en` is 0x0F, so the oscillator supply is off. In mode 5, `lowq` is 1 and `sys_rst_n` is 1.
- R8: `sw_flash` is acted on only in mode 4. In mode 6 the outputs are identical to mode 4.
- R9: `sw_wake` in mode 5 or mode 6 returns the block to mode 4.
- R10: A `wake_key` press in mode 4 sets `pd_req` and leaves the mode unchanged. `pd_req` stays set while the block is in mode 4 and clears when it leaves.
- R11: `sw_off` in mode 4 or mode 6 returns the block to mode 2. In mode 4 the priority order is `sw_off`, then `sw_sleep`, then `sw_flash`.
- R12: The mode codes are: 0 no supply, 1 back-up, 2 off, 3 start-up reset, 4 on, 5 sleep, 6 flashing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok | input | 1 | Main battery above master-reset threshold |
| backup_ok | input | 1 | Back-up cell voltage adequate |
| rtc_run | input | 1 | Real-time-clock oscillator running |
| tick32 | input | 1 | One-cycle pulse per 32.768 kHz period |
| wake_key | input | 1 | Power key press |
| wake_chg | input | 1 | Charger connected |
| wake_rtc | input | 1 | Alarm event |
| wake_bus | input | 1 | Serial-bus wake event |
| sw_sleep | input | 1 | Software sleep request |
| sw_flash | input | 1 | Software flashing request |
| sw_wake | input | 1 | Software return to full operation |
| sw_off | input | 1 | Software power-off command |
| mode | output | 3 | Registered mode code |
| reg_en | output | 5 | Regulator enables |
| lowq | output | 1 | Low-quiescent mode for the sleep set |
| sys_rst_n | output | 1 | Active-low system reset |
| pd_req | output | 1 | Power-down request flag to software |

## Verification
The assertions check four things on every cycle. A battery drop always lands in a no-power mode with the supplies off. The reset is released only when leaving the start-up mode. Sleep and flashing are reached only through the on mode. The enables always form a thermometer code, and the sleep outputs follow that code. The tick count, the order in which supplies switch on during start-up, the equivalence of the four wake sources and the request priorities are shown only by the bench scenarios. The bench uses a short delay and sweeps every wake source and every back-up flag combination.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int DELAY_TICKS = 524,
  parameter int NREG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_ok,
  input  logic            backup_ok,
  input  logic            rtc_run,
  input  logic            tick32,
  input  logic            wake_key,
  input  logic            wake_chg,
  input  logic            wake_rtc,
  input  logic            wake_bus,
  input  logic            sw_sleep,
  input  logic            sw_flash,
  input  logic            sw_wake,
  input  logic            sw_off,
  output logic [2:0]      mode,
  output logic [NREG-1:0] reg_en,
  output logic            lowq,
  output logic            sys_rst_n,
  output logic            pd_req
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [2:0] M_NONE = 3'd0, M_BKUP = 3'd1, M_OFF = 3'd2, M_RST = 3'd3,
                         M_ON = 3'd4, M_SLP = 3'd5, M_FLSH = 3'd6;
  localparam logic [CW-1:0] LOAD = CW'(DELAY_TICKS);

  logic [CW-1:0]   cnt, ncnt;
  logic [2:0]      nmode;
  logic            npd;
  logic [NREG-1:0] nen;
  wire wake_any = wake_key | wake_chg | wake_rtc | wake_bus;

  always_comb begin
    nmode = mode;
    ncnt  = cnt;
    npd   = pd_req;
    if (!main_ok)
      nmode = (backup_ok && rtc_run) ? M_BKUP : M_NONE;
    else begin
      case (mode)
        M_NONE, M_BKUP: nmode = M_OFF;
        M_OFF: if (wake_any) begin nmode = M_RST; ncnt = LOAD; end
        M_RST: if (tick32) begin
          if (cnt == CW'(1)) nmode = M_ON;
          ncnt = cnt - CW'(1);
        end
        M_ON: begin
          if (sw_off)        nmode = M_OFF;
          else if (sw_sleep) nmode = M_SLP;
          else if (sw_flash) nmode = M_FLSH;
          else if (wake_key) npd = 1'b1;
        end
        M_SLP:  if (sw_wake) nmode = M_ON;
        M_FLSH: begin
          if (sw_off)       nmode = M_OFF;
          else if (sw_wake) nmode = M_ON;
        end
        default: nmode = M_NONE;
      endcase
    end
    if (nmode != M_ON) npd = 1'b0;
  end

  always_comb begin
    nen = '0;
    case (nmode)
      M_RST:        for (int i = 0; i < NREG; i++) nen[i] = int'(ncnt) <= DELAY_TICKS - i;
      M_ON, M_FLSH: nen = '1;
      M_SLP:        nen = {1'b0, {(NREG-1){1'b1}}};
      default:      nen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_NONE;
      cnt       <= '0;
      pd_req    <= 1'b0;
      reg_en    <= '0;
      lowq      <= 1'b0;
      sys_rst_n <= 1'b0;
    end else begin
      mode      <= nmode;
      cnt       <= ncnt;
      pd_req    <= npd;
      reg_en    <= nen;
      lowq      <= nmode == M_SLP;
      sys_rst_n <= nmode == M_ON || nmode == M_SLP || nmode == M_FLSH;
    end
  end
endmodule

module pwr_mode_seq_chk #(parameter int NREG = 5) (
  input logic            clk,
  input logic            rst_n,
  input logic            main_ok,
  input logic [2:0]      mode,
  input logic [NREG-1:0] reg_en,
  input logic            lowq,
  input logic            sys_rst_n,
  input logic            pd_req
);
  a_r2_battery_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |=> (mode == 3'd0 || mode == 3'd1) && reg_en == '0 && !sys_rst_n);
  a_r6_release_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(mode) == 3'd3 && mode == 3'd4);
  a_r7_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |-> $past(mode) == 3'd4 || $past(mode) == 3'd5);
  a_r7_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |-> lowq && sys_rst_n && !reg_en[NREG-1] && reg_en[0]);
  a_r8_flash_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd6 |-> $past(mode) == 3'd4 || $past(mode) == 3'd6);
  a_r5_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_en + 1'b1) & reg_en) == '0);
  a_r10_pdreq_on_only: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> mode == 3'd4);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .mode(mode), .reg_en(reg_en),
  .lowq(lowq), .sys_rst_n(sys_rst_n), .pd_req(pd_req));

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int D = 12;
  logic clk = 0, rst_n = 0;
  logic main_ok = 0, backup_ok = 0, rtc_run = 0, tick32 = 0;
  logic wake_key = 0, wake_chg = 0, wake_rtc = 0, wake_bus = 0;
  logic sw_sleep = 0, sw_flash = 0, sw_wake = 0, sw_off = 0;
  logic [2:0] mode;
  logic [4:0] reg_en;
  logic lowq, sys_rst_n, pd_req;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.DELAY_TICKS(D)) u0 (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic outs(string req, int m, int en, int rs, int lq);
    chk({req, " mode"}, mode, m);
    chk({req, " reg_en"}, reg_en, en);
    chk({req, " sys_rst_n"}, sys_rst_n, rs);
    chk({req, " lowq"}, lowq, lq);
  endtask

  task automatic pulse(ref logic s); s = 1; step(); s = 0; endtask

  task automatic bring_up(int w);
    case (w)
      0: wake_key = 1;
      1: wake_chg = 1;
      2: wake_rtc = 1;
      default: wake_bus = 1;
    endcase
    step();
    {wake_key, wake_chg, wake_rtc, wake_bus} = '0;
    outs("R4 entry", 3, 1, 0, 0);
    for (int k = 1; k <= D; k++) begin
      pulse(tick32);
      step();
      if (k < D) outs("R5 stage", 3, (1 << ((k + 1 > 5) ? 5 : k + 1)) - 1, 0, 0);
    end
    outs("R6 release", 4, 31, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    outs("R1 reset", 0, 0, 0, 0);
    chk("R1 pd_req", pd_req, 0);
    for (int b = 0; b < 4; b++) begin
      {backup_ok, rtc_run} = 2'(b);
      step();
      outs("R2 sweep", (b == 3) ? 1 : 0, 0, 0, 0);
    end
    main_ok = 1; step();
    outs("R3 to off", 2, 0, 0, 0);
    sw_sleep = 1; sw_flash = 1; step(); sw_sleep = 0; sw_flash = 0;
    outs("R7 R8 ignored in off", 2, 0, 0, 0);
    for (int w = 0; w < 4; w++) begin
      bring_up(w);
      case (w)
        0: begin
          pulse(wake_key);
          chk("R10 pd_req", pd_req, 1); chk("R10 mode", mode, 4);
          step(); chk("R10 hold", pd_req, 1);
          pulse(sw_sleep);
          outs("R7 sleep", 5, 15, 1, 1); chk("R10 clear", pd_req, 0);
          pulse(sw_flash); outs("R8 ignored in sleep", 5, 15, 1, 1);
          pulse(sw_wake); outs("R9 wake from sleep", 4, 31, 1, 0);
          pulse(sw_flash); outs("R8 flash", 6, 31, 1, 0);
          pulse(sw_off); outs("R11 off from flash", 2, 0, 0, 0);
        end
        1: begin
          sw_off = 1; sw_sleep = 1; sw_flash = 1; step();
          sw_off = 0; sw_sleep = 0; sw_flash = 0;
          outs("R11 off priority", 2, 0, 0, 0);
        end
        2: begin
          sw_sleep = 1; sw_flash = 1; step(); sw_sleep = 0; sw_flash = 0;
          outs("R11 sleep over flash", 5, 15, 1, 1);
          main_ok = 0; backup_ok = 1; rtc_run = 1; step();
          outs("R2 drop in sleep", 1, 0, 0, 0);
          main_ok = 1; step(); outs("R3 recover", 2, 0, 0, 0);
        end
        default: begin
          pulse(sw_flash); outs("R8 flash", 6, 31, 1, 0);
          pulse(sw_wake); outs("R9 wake from flash", 4, 31, 1, 0);
          pulse(sw_off); outs("R11 off from on", 2, 0, 0, 0);
        end
      endcase
    end
    pulse(wake_bus);
    for (int k = 0; k < 3; k++) begin pulse(tick32); end
    outs("R5 partial", 3, 15, 0, 0);
    repeat (5) step();
    outs("R6 no tick no advance", 3, 15, 0, 0);
    main_ok = 0; backup_ok = 0; step();
    outs("R2 drop in reset", 0, 0, 0, 0);
    chk("R12 code width", $bits(mode), 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule